// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block watches a bank of general-purpose pins, grouped into ports of eight, and raises an active-low interrupt request when any pin that is set up as an input moves away from the level last captured for its port. Each pin passes through a two-flop synchroniser and is then compared with a per-port reference snapshot. The interrupt line is modelled as an open-drain pull-down enable, together with the wire level that the enable implies.

The interrupt drops on its own when every differing input pin returns to its snapshot value. It is also cleared by a read of the port. The register interface gives one strobe per port during the acknowledge phase of each byte it returns. On that strobe the port's snapshot is reloaded from the synchronised pins, so the pending difference disappears. Pins set up as outputs take no part in the comparison. When a pin is turned from output back to input and its level differs from the snapshot, the interrupt is raised straight away.

After reset the snapshots follow the synchronised pins for a short priming window. During that window the interrupt is held inactive, so the levels present at power-up do not raise an interrupt.

Top module: `port_change_irq`

## Requirements
- R1: While reset is low, and for the first three clocks after it is released, `irq_oe` is 0 and `irq_n` is 1. Once that window has passed, snapshots hold the pin levels that were present at release, so static pins raise no interrupt.
- R2: A rising or a falling edge on a pin whose `dir_in` bit is 1 (1 = input) sets `irq_oe` at the third rising clock edge after the pin changes.
- R3: A pin whose `dir_in` bit is 0 (output) never sets `irq_oe`, whatever its level does.
- R4: If every differing input pin returns to its snapshot level, `irq_oe` goes low at the third rising edge after that return, with no read needed.
- R5: A one-cycle `rd_ack[p]` pulse (bit 0 covers pins 7:0, bit 1 covers pins 15:8) reloads port p's snapshot from the synchronised pins at that edge. A pending interrupt from that port clears at the following edge.
- R6: Ports are tracked independently. An acknowledge on one port leaves an interrupt caused by the other port in place.
- R7: After a clear, a new change on an input pin is detected again and raises `irq_oe` with the R2 timing.
- R8: Changing a pin's `dir_in` bit from 0 to 1 while its synchronised level differs from the snapshot sets `irq_oe` at the next rising edge.
- R9: When a change reaches the synchroniser output in the same cycle as its port's acknowledge, it is absorbed into the new snapshot. It produces at most a one-cycle pulse on `irq_oe`.
- R10: `irq_n` is always the complement of `irq_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | 16 | Asynchronous pin levels, port 0 in bits 7:0 |
| dir_in | input | 16 | Per-pin direction, 1 = input, 0 = output |
| rd_ack | input | 2 | Per-port strobe in the acknowledge phase of a read byte |
| irq_oe | output | 1 | Open-drain pull-down enable for the interrupt line |
| irq_n | output | 1 | Resulting interrupt level, active low |

## Verification
The assertions assume that `rd_ack` is a clean single-clock strobe per port and that `dir_in` is already in the clock domain. They do not assume that the pins are quiet or slow. The stimulus changes `dir_in` and `rd_ack` only at the falling edge, and it holds each acknowledge for exactly one cycle. Pin edges are placed both well clear of an acknowledge and exactly on one, to reach the absorbed-change case. Random phases mix all three inputs under the same falling-edge discipline.

// File: rtl/pcig_pkg.sv
// Shared defaults and helpers for the port change interrupt generator.
// Assumes: ports are equal-width slices of the pin vector.
package pcig_pkg;
    parameter int unsigned DEF_PORT_W      = 8;
    parameter int unsigned DEF_NUM_PORTS   = 2;
    parameter int unsigned DEF_SYNC_STAGES = 2;

    // Priming window: snapshots must see a filled synchroniser before arming.
    function automatic int unsigned prime_cycles(input int unsigned stages);
        return stages + 1;
    endfunction
endpackage

// File: rtl/pcig_sync.sv
// Multi-stage flop synchroniser for a vector of asynchronous pins.
// Assumes: each bit is independent; no bus coherence is required.
module pcig_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    // Shift the pin vector through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pcig_port_track.sv
// Per-port snapshot and difference detector.
// The snapshot follows the synchronised pins until armed, then reloads only
// on the acknowledge strobe of a read of this port. Pending is any input pin
// that differs from the snapshot.
// Assumes: rd_ack_i is a single-cycle strobe in the clk domain.
module pcig_port_track #(
    parameter int unsigned PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed_i,
    input  logic              rd_ack_i,
    input  logic [PORT_W-1:0] sync_i,
    input  logic [PORT_W-1:0] dir_i,
    output logic              pend_o
);
    logic [PORT_W-1:0] snap_q;

    // Reload the snapshot while priming or on a read acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                    snap_q <= '0;
        else if (!armed_i || rd_ack_i) snap_q <= sync_i;
    end

    // Flag a difference on any pin configured as input.
    assign pend_o = |((sync_i ^ snap_q) & dir_i);

    AST_ACK_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack_i |=> (snap_q == $past(sync_i)));                       // R5
    AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && !rd_ack_i) |=> $stable(snap_q));                   // R4
endmodule

// File: rtl/port_change_irq.sv
// Port change interrupt generator: synchronises the pins, tracks one
// snapshot per port and drives an open-drain-style active-low request.
// Assumes: dir_in and rd_ack are synchronous to clk; pin_in is asynchronous.
module port_change_irq
    import pcig_pkg::*;
#(
    parameter int unsigned PORT_W      = DEF_PORT_W,
    parameter int unsigned NUM_PORTS   = DEF_NUM_PORTS,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PORT_W*NUM_PORTS-1:0]   pin_in,
    input  logic [PORT_W*NUM_PORTS-1:0]   dir_in,
    input  logic [NUM_PORTS-1:0]          rd_ack,
    output logic                          irq_oe,
    output logic                          irq_n
);
    localparam int unsigned PIN_W = PORT_W * NUM_PORTS;
    localparam int unsigned PRIME = prime_cycles(SYNC_STAGES);
    localparam int unsigned ARM_W = $clog2(PRIME + 1);

    logic [PIN_W-1:0]     pin_sync;
    logic [NUM_PORTS-1:0] pend;
    logic [ARM_W-1:0]     arm_q;
    logic                 armed;
    logic                 irq_q;

    pcig_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in),
        .q_o   (pin_sync)
    );

    for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_port
        pcig_port_track #(.PORT_W(PORT_W)) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .armed_i  (armed),
            .rd_ack_i (rd_ack[p]),
            .sync_i   (pin_sync[p*PORT_W +: PORT_W]),
            .dir_i    (dir_in[p*PORT_W +: PORT_W]),
            .pend_o   (pend[p])
        );
    end

    assign armed = (arm_q == ARM_W'(PRIME));

    // Count the priming window after reset, then stay armed.
    always_ff @(posedge clk) begin
        if (!rst_n)      arm_q <= '0;
        else if (!armed) arm_q <= arm_q + 1'b1;
    end

    // Register the combined request so the pin drive is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= armed && (|pend);
    end

    assign irq_oe = irq_q;
    assign irq_n  = ~irq_q;

    AST_PRIME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !irq_oe);                                           // R1
    AST_OUTPUTS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in == '0) |=> !irq_oe);                                   // R3
    AST_LEVEL_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n != irq_oe);                                              // R10
endmodule

// File: tb/port_change_irq_bench.sv
module port_change_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin = '0;
    logic [15:0] dir = '1;
    logic [1:0]  ack = '0;
    logic        irq_oe, irq_n;

    int checks = 0, fails = 0, cyc = 0;
    string cur_req = "R1";

    // Behavioural reference state.
    logic [15:0] m_hist [$];
    logic [15:0] m_snap = '0;
    int          m_age = 0;
    logic        m_irq = 1'b0;

    always #2 clk = ~clk;

    port_change_irq u_port_change_irq (
        .clk(clk), .rst_n(rst_n), .pin_in(pin), .dir_in(dir),
        .rd_ack(ack), .irq_oe(irq_oe), .irq_n(irq_n)
    );

    // Reference model: pins visible two edges late, snapshot reloads on ack.
    always @(posedge clk) begin
        logic [15:0] seen;
        if (!rst_n) begin
            m_hist = '{16'h0, 16'h0};
            m_snap = '0; m_age = 0; m_irq = 1'b0;
        end else begin
            seen  = m_hist[0];
            m_irq = (m_age >= 3) && (((seen ^ m_snap) & dir) != 0);
            if (m_age < 3) m_snap = seen;
            else begin
                if (ack[0]) m_snap[7:0]  = seen[7:0];
                if (ack[1]) m_snap[15:8] = seen[15:8];
            end
            if (m_age < 3) m_age++;
            void'(m_hist.pop_front());
            m_hist.push_back(pin);
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        cyc++;
        checks++;
        if (irq_oe !== m_irq || irq_n !== ~m_irq) begin
            fails++;
            $display("FAIL %s cyc %0d: irq_oe=%b irq_n=%b expected %b/%b",
                     cur_req, cyc, irq_oe, irq_n, m_irq, ~m_irq);
        end
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected under 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Hand-derived expectation, independent of the model.
    task automatic expect_irq(input logic exp, input string req);
        checks++;
        if (irq_oe !== exp || irq_n !== ~exp) begin
            fails++;
            $display("FAIL %s: irq_oe=%b irq_n=%b expected %b", req, irq_oe, irq_n, exp);
        end
    endtask

    task automatic pulse_ack(input logic [1:0] a);
        ack = a; step(1); ack = '0;
    endtask

    initial begin
        cur_req = "R1";
        pin = 16'h0081;
        step(3);
        expect_irq(1'b0, "R1");
        rst_n = 1'b1;
        step(1); expect_irq(1'b0, "R1");
        step(5); expect_irq(1'b0, "R1");

        cur_req = "R2";
        pin[3] = 1'b1;
        step(2); expect_irq(1'b0, "R2");
        step(1); expect_irq(1'b1, "R2");

        cur_req = "R4";
        pin[3] = 1'b0;
        step(2); expect_irq(1'b1, "R4");
        step(1); expect_irq(1'b0, "R4");

        cur_req = "R5";
        pin[12] = 1'b1;
        step(3); expect_irq(1'b1, "R5");
        pulse_ack(2'b10);
        expect_irq(1'b1, "R5");
        step(1); expect_irq(1'b0, "R5");

        cur_req = "R6";
        pin[12] = 1'b0; pin[2] = 1'b1;
        step(4); expect_irq(1'b1, "R6");
        pulse_ack(2'b01);
        step(1); expect_irq(1'b1, "R6");
        pulse_ack(2'b10);
        step(1); expect_irq(1'b0, "R6");

        cur_req = "R7";
        pin[2] = 1'b0;
        step(3); expect_irq(1'b1, "R7");
        pulse_ack(2'b01);
        step(1); expect_irq(1'b0, "R7");
        pin[2] = 1'b1;
        step(3); expect_irq(1'b1, "R7");
        pulse_ack(2'b01);
        step(1); expect_irq(1'b0, "R7");

        cur_req = "R3";
        dir = 16'hFF00;
        pin[5] = 1'b1;
        step(5); expect_irq(1'b0, "R3");

        cur_req = "R8";
        dir = 16'hFFFF;
        step(1); expect_irq(1'b1, "R8");
        pulse_ack(2'b01);
        step(1); expect_irq(1'b0, "R8");

        cur_req = "R3";
        dir = '0;
        for (int i = 0; i < 40; i++) begin
            pin = 16'($urandom);
            step(1);
            expect_irq(1'b0, "R3");
        end
        pulse_ack(2'b11);
        pin = 16'h0000;
        step(4);
        pulse_ack(2'b11);
        dir = '1;
        step(3); expect_irq(1'b0, "R3");

        cur_req = "R9";
        pin[9] = 1'b1;
        step(2);
        pulse_ack(2'b10);
        expect_irq(1'b1, "R9");
        step(1); expect_irq(1'b0, "R9");
        step(4); expect_irq(1'b0, "R9");

        cur_req = "R2";
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(3) == 0) pin[$urandom_range(15)] ^= 1'b1;
            if ($urandom_range(9) == 0) dir = 16'($urandom);
            ack = 2'($urandom_range(5) == 0 ? $urandom_range(3) : 0);
            step(1);
        end
        ack = '0;

        cur_req = "R1";
        rst_n = 1'b0;
        step(2); expect_irq(1'b0, "R1");
        rst_n = 1'b1;
        step(3); expect_irq(1'b0, "R1");

        cur_req = "R10";
        step(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule